// File: doc/BRIEF.md
# Coarse Gold Code Spreading Sequence Generator

This block produces the 1023-chip coarse spreading sequence for one satellite, chosen by a PRN number from 1 to 37. Two 10-stage maximal-length shift registers run side by side. The chip comes from the last stage of the first register, XORed with two stages of the second register. The PRN number picks those two stages. Picking two stages gives each satellite its own code delay without a delay line. This works because the XOR of two phases of a maximal-length sequence is the same sequence at another phase.

The registers advance only on cycles where the chip-enable input is high. In the system that enable comes from dividing the 10.23 MHz clock by ten. A counter marks the end of each 1023-chip code period with a one-cycle code-epoch strobe. A second counter raises a data-bit epoch on every twentieth code epoch. A load strobe restarts the sequence and both counters on the next enabled chip. An out-of-range PRN number holds the chip at 0 and raises an error flag.

Top module: `gold_prn_gen`

## Requirements
- R1: The registers and counters change only on clock edges where `chip_en` is high. With `chip_en` low, `chip_out` and the epoch strobes hold steady.
- R2: After reset, both registers hold all ones. Register A takes its feedback from stages 3 and 10. Register B takes its feedback from stages 2, 3, 6, 8, 9 and 10. Neither register ever holds all zeros.
- R3: `chip_out` is stage 10 of register A, XORed with two stages of register B. The first ten chips after a restart, first chip on the left, are 1100100000 for PRN 1 and 1001011011 for PRN 5.
- R4: The tap pairs on register B are fixed per PRN. They include 1:(2,6), 2:(3,7), 5:(1,9), 7:(1,8), 10:(2,3), 23:(1,3), 29:(1,6) and 35:(1,7). PRN 34 and PRN 37 both use (4,10) and give identical chips. The first ten chips are 1110010000 for PRN 2, 1101000100 for PRN 10, 1000110011 for PRN 23, 1001011100 for PRN 35 and 1111001011 for PRN 34 and PRN 37.
- R5: The chip sequence repeats with a period of exactly 1023 enabled chips.
- R6: `code_epoch` is high, combinationally, in the cycle that carries the 1023rd enable of a period (chip index 1022). The chip that follows is the first chip of the sequence.
- R7: `data_epoch` is high only together with `code_epoch`, on every twentieth code epoch. The first one falls on enable number 20460 after a reset or restart.
- R8: A `load` pulse restarts both registers and both counters on the next cycle with `chip_en` high. That can be the same cycle as the pulse. If `chip_en` is low, the restart is held pending and the chip does not change until the enable arrives. The restarting enable raises no `code_epoch`.
- R9: A PRN number of 0 or above 37 gives `prn_err` = 1 and `chip_out` = 0. A PRN number from 1 to 37 gives `prn_err` = 0.
- R10: During and right after reset, `chip_out` shows the first chip of the selected code, and both epoch strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip-rate enable, one cycle per chip |
| load | input | 1 | Restart request, applied on the next enabled chip |
| prn_sel | input | 6 | PRN number, valid from 1 to 37 |
| chip_out | output | 1 | Current spreading chip |
| code_epoch | output | 1 | High on the enable that ends a 1023-chip period |
| data_epoch | output | 1 | High on every twentieth code epoch |
| prn_err | output | 1 | PRN number out of range |

## Verification
The bench compares the first ten chips of several PRNs with known bit patterns. A wrong feedback tap or a wrong entry in the tap table would show up there as a different bit pattern. It follows one full data-bit interval of 20460 enables and checks three things: the chips repeat after 1023, the code epoch falls exactly on index 1022, and the data epoch falls exactly on enable 20460. A counter that is off by one would move these strobes by a chip or a whole code period. The directed tests cover three load cases: a load with the enable low, a load with the enable high, and a load on the final chip of a period. A design that ignored the pending load, or let an epoch through on the restart, would fail these. Invalid PRN numbers must force the chip to zero.

// File: rtl/gold_prn_pkg.sv
package gold_prn_pkg;

    localparam int NSTG     = 10;
    localparam int CODE_LEN = 1023;
    localparam int EP_PER_BIT = 20;
    localparam int MAX_PRN  = 37;

    typedef logic [NSTG:1] stage_vec_t;

    // Feedback masks, bit i = stage i
    localparam stage_vec_t REG_A_FB = 10'b10_0000_0100;   // stages 10,3
    localparam stage_vec_t REG_B_FB = 10'b11_1010_0110;   // stages 10,9,8,6,3,2

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
    } tap_pair_t;

    function automatic tap_pair_t tap_pair(input int unsigned x, input int unsigned y);
        tap_pair_t t;
        t.a = 4'(x);
        t.b = 4'(y);
        return t;
    endfunction

    // Per-PRN stage pair on register B; zeros for an invalid number
    function automatic tap_pair_t prn_taps(input logic [5:0] prn);
        case (prn)
            6'd1:  return tap_pair(2, 6);
            6'd2:  return tap_pair(3, 7);
            6'd3:  return tap_pair(4, 8);
            6'd4:  return tap_pair(5, 9);
            6'd5:  return tap_pair(1, 9);
            6'd6:  return tap_pair(2, 10);
            6'd7:  return tap_pair(1, 8);
            6'd8:  return tap_pair(2, 9);
            6'd9:  return tap_pair(3, 10);
            6'd10: return tap_pair(2, 3);
            6'd11: return tap_pair(3, 4);
            6'd12: return tap_pair(5, 6);
            6'd13: return tap_pair(6, 7);
            6'd14: return tap_pair(7, 8);
            6'd15: return tap_pair(8, 9);
            6'd16: return tap_pair(9, 10);
            6'd17: return tap_pair(1, 4);
            6'd18: return tap_pair(2, 5);
            6'd19: return tap_pair(3, 6);
            6'd20: return tap_pair(4, 7);
            6'd21: return tap_pair(5, 8);
            6'd22: return tap_pair(6, 9);
            6'd23: return tap_pair(1, 3);
            6'd24: return tap_pair(4, 6);
            6'd25: return tap_pair(5, 7);
            6'd26: return tap_pair(6, 8);
            6'd27: return tap_pair(7, 9);
            6'd28: return tap_pair(8, 10);
            6'd29: return tap_pair(1, 6);
            6'd30: return tap_pair(2, 7);
            6'd31: return tap_pair(3, 8);
            6'd32: return tap_pair(4, 9);
            6'd33: return tap_pair(5, 10);
            6'd34: return tap_pair(4, 10);
            6'd35: return tap_pair(1, 7);
            6'd36: return tap_pair(2, 8);
            6'd37: return tap_pair(4, 10);
            default: return tap_pair(0, 0);
        endcase
    endfunction

endpackage

// File: rtl/prn_lfsr.sv
module prn_lfsr #(
    parameter int N = gold_prn_pkg::NSTG,
    parameter logic [N:1] FB_MASK = gold_prn_pkg::REG_A_FB
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       reload,
    output logic [N:1] state
);

    logic fb;

    always_comb fb = ^(state & FB_MASK);

    always_ff @(posedge clk) begin
        if (rst || (adv && reload))
            state <= '1;
        else if (adv)
            state <= {state[N-1:1], fb};
    end

    // R2: the all-zero state never occurs
    assert_never_zero_R2: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R1: state frozen without an enable
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

endmodule

// File: rtl/prn_tap_select.sv
module prn_tap_select #(
    parameter int MAX_PRN = gold_prn_pkg::MAX_PRN,
    parameter int N = gold_prn_pkg::NSTG
) (
    input  logic [5:0]                  prn,
    output gold_prn_pkg::tap_pair_t     taps,
    output logic                        bad
);

    always_comb begin
        bad  = (prn == 6'd0) || (int'(prn) > MAX_PRN);
        taps = gold_prn_pkg::prn_taps(prn);
        if (!bad) begin
            // R4: a valid PRN always names two distinct real stages
            assert_tap_range_R4: assert ((taps.a >= 4'd1) && (int'(taps.b) <= N)
                                         && (taps.a < taps.b));
        end
    end

endmodule

// File: rtl/prn_epoch_ctr.sv
module prn_epoch_ctr #(
    parameter int CODE_LEN   = gold_prn_pkg::CODE_LEN,
    parameter int EP_PER_BIT = gold_prn_pkg::EP_PER_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic restart,
    output logic code_wrap,
    output logic bit_wrap
);

    localparam int CW = $clog2(CODE_LEN);
    localparam int EW = $clog2(EP_PER_BIT);
    localparam logic [CW-1:0] LAST_CHIP = CW'(CODE_LEN - 1);
    localparam logic [EW-1:0] LAST_EP   = EW'(EP_PER_BIT - 1);

    logic [CW-1:0] chip_idx;
    logic [EW-1:0] ep_idx;

    always_comb begin
        code_wrap = adv && !restart && (chip_idx == LAST_CHIP);
        bit_wrap  = code_wrap && (ep_idx == LAST_EP);
    end

    always_ff @(posedge clk) begin
        if (rst || (adv && restart)) begin
            chip_idx <= '0;
            ep_idx   <= '0;
        end else if (adv) begin
            if (code_wrap) begin
                chip_idx <= '0;
                ep_idx   <= bit_wrap ? '0 : ep_idx + 1'b1;
            end else begin
                chip_idx <= chip_idx + 1'b1;
            end
        end
    end

    // R7: a bit epoch always coincides with a code epoch
    assert_bit_in_code_R7: assert property (@(posedge clk) disable iff (rst)
        bit_wrap |-> code_wrap);

    // R6: the chip index never leaves the code period
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
        chip_idx <= LAST_CHIP);

endmodule

// File: rtl/gold_prn_gen.sv
module gold_prn_gen #(
    parameter int CODE_LEN   = gold_prn_pkg::CODE_LEN,
    parameter int EP_PER_BIT = gold_prn_pkg::EP_PER_BIT,
    parameter int MAX_PRN    = gold_prn_pkg::MAX_PRN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_en,
    input  logic       load,
    input  logic [5:0] prn_sel,
    output logic       chip_out,
    output logic       code_epoch,
    output logic       data_epoch,
    output logic       prn_err
);

    import gold_prn_pkg::*;

    stage_vec_t reg_a, reg_b;
    tap_pair_t  taps;
    logic       load_pend;
    logic       restart;
    logic       reg_reload;
    logic       raw_chip;

    always_comb begin
        restart    = load || load_pend;
        reg_reload = restart || code_epoch;
    end

    always_ff @(posedge clk) begin
        if (rst)
            load_pend <= 1'b0;
        else if (chip_en)
            load_pend <= 1'b0;
        else if (load)
            load_pend <= 1'b1;
    end

    prn_lfsr #(.N(NSTG), .FB_MASK(REG_A_FB)) u_reg_a (
        .clk(clk), .rst(rst), .adv(chip_en), .reload(reg_reload), .state(reg_a)
    );

    prn_lfsr #(.N(NSTG), .FB_MASK(REG_B_FB)) u_reg_b (
        .clk(clk), .rst(rst), .adv(chip_en), .reload(reg_reload), .state(reg_b)
    );

    prn_tap_select #(.MAX_PRN(MAX_PRN), .N(NSTG)) u_taps (
        .prn(prn_sel), .taps(taps), .bad(prn_err)
    );

    prn_epoch_ctr #(.CODE_LEN(CODE_LEN), .EP_PER_BIT(EP_PER_BIT)) u_epoch (
        .clk(clk), .rst(rst), .adv(chip_en), .restart(restart),
        .code_wrap(code_epoch), .bit_wrap(data_epoch)
    );

    always_comb begin
        raw_chip = reg_a[NSTG] ^ reg_b[taps.a] ^ reg_b[taps.b];
        chip_out = prn_err ? 1'b0 : raw_chip;
    end

    // R6: after a code epoch both registers are back at all ones
    assert_epoch_realign_R6: assert property (@(posedge clk) disable iff (rst)
        code_epoch |=> (reg_a == '1) && (reg_b == '1));

    // R8: an enabled restart puts both registers at all ones
    assert_load_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (chip_en && restart) |=> (reg_a == '1) && (reg_b == '1));

    // R9: an invalid PRN keeps the chip at zero
    assert_bad_prn_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        prn_err |-> !chip_out);

endmodule

// File: tb/gold_prn_gen_tb.sv
`timescale 1ns/1ps
module gold_prn_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_en = 1'b0;
    logic       load = 1'b0;
    logic [5:0] prn_sel = 6'd1;
    logic       chip_out, code_epoch, data_epoch, prn_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    gold_prn_gen u_dut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .load(load), .prn_sel(prn_sel),
        .chip_out(chip_out), .code_epoch(code_epoch), .data_epoch(data_epoch),
        .prn_err(prn_err)
    );

    // {prn, first ten chips, first chip on the left}
    localparam int NVEC = 10;
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {6'd1,  10'b1100100000},
        {6'd5,  10'b1001011011},
        {6'd2,  10'b1110010000},
        {6'd7,  10'b1001011001},
        {6'd10, 10'b1101000100},
        {6'd23, 10'b1000110011},
        {6'd29, 10'b1001010111},
        {6'd35, 10'b1001011100},
        {6'd34, 10'b1111001011},
        {6'd37, 10'b1111001011}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic en, input logic ld);
        chip_en = en;
        load    = ld;
        @(negedge clk);
        chip_en = 1'b0;
        load    = 1'b0;
    endtask

    task automatic read10(output logic [9:0] bits);
        for (int i = 9; i >= 0; i--) begin
            bits[i] = chip_out;
            tick(1'b1, 1'b0);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [9:0] got;
        logic       first_per [0:1022];
        int bad_rep, bad_cep, bad_dep, ncep;
        logic c0;

        // R10: reset state
        @(negedge clk); @(negedge clk);
        chk("R10 chip during reset", chip_out, 1);
        chk("R10 code_epoch in reset", code_epoch, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 chip after reset", chip_out, 1);
        chk("R10 data_epoch after reset", data_epoch, 0);
        chk("R9 valid prn no error", prn_err, 0);

        // R3 / R4: first ten chips per PRN, restart by load with enable
        for (int v = 0; v < NVEC; v++) begin
            prn_sel = VEC[v][15:10];
            tick(1'b1, 1'b1);
            read10(got);
            chk($sformatf("R3 R4 first chips prn %0d", VEC[v][15:10]),
                int'(got), int'(VEC[v][9:0]));
        end

        // R5 / R6 / R7: one full data-bit interval from a restart
        prn_sel = 6'd1;
        tick(1'b1, 1'b1);
        bad_rep = 0; bad_cep = 0; bad_dep = 0; ncep = 0;
        for (int n = 0; n < 20460; n++) begin
            if (n < 1023) first_per[n] = chip_out;
            else if (chip_out != first_per[n % 1023]) bad_rep++;
            chip_en = 1'b1;
            #1;
            if (code_epoch) ncep++;
            if (code_epoch != ((n % 1023) == 1022)) bad_cep++;
            if (data_epoch != (n == 20459)) bad_dep++;
            @(negedge clk);
            chip_en = 1'b0;
        end
        chk("R5 period repeats after 1023", bad_rep, 0);
        chk("R6 code epoch position", bad_cep, 0);
        chk("R6 code epoch count", ncep, 20);
        chk("R7 data epoch position", bad_dep, 0);
        read10(got);
        chk("R6 sequence restarts after epoch", int'(got), int'(10'b1100100000));

        // R1: no enable, no change
        c0 = chip_out;
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b0);
        chk("R1 chip holds without enable", chip_out, c0);
        chk("R1 no epoch without enable", code_epoch, 0);

        // R8: pending load with enable low
        tick(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        chk("R8 index5 chip before load", chip_out, 0);
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        chk("R8 pending load waits for enable", chip_out, 0);
        tick(1'b1, 1'b0);
        chk("R8 pending load applied", chip_out, 1);
        tick(1'b0, 1'b0);
        read10(got);
        chk("R8 sequence after pending load", int'(got), int'(10'b1100100000));

        // R8: load on the final chip suppresses the epoch
        tick(1'b1, 1'b1);
        for (int i = 0; i < 1022; i++) tick(1'b1, 1'b0);
        chip_en = 1'b1; load = 1'b1;
        #1;
        chk("R8 no code epoch on restart", code_epoch, 0);
        @(negedge clk);
        chip_en = 1'b0; load = 1'b0;
        read10(got);
        chk("R8 sequence after final-chip load", int'(got), int'(10'b1100100000));

        // R9: invalid PRN numbers
        prn_sel = 6'd0;  #1;
        chk("R9 prn 0 error", prn_err, 1);
        chk("R9 prn 0 chip", chip_out, 0);
        prn_sel = 6'd38; #1;
        chk("R9 prn 38 error", prn_err, 1);
        prn_sel = 6'd63; tick(1'b1, 1'b1);
        got = '1;
        for (int i = 0; i < 10; i++) begin
            got[i] = chip_out;
            tick(1'b1, 1'b0);
        end
        chk("R9 prn 63 chips all zero", int'(got), 0);
        prn_sel = 6'd37; #1;
        chk("R9 prn 37 valid", prn_err, 0);

        // R10: reset mid-run
        prn_sel = 6'd5;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
        rst = 1'b1;
        tick(1'b0, 1'b0);
        rst = 1'b0;
        read10(got);
        chk("R10 R2 sequence after reset", int'(got), int'(10'b1001011011));

        summary();
    end

endmodule